// File: doc/BRIEF.md
# Maskable Latched Event Status Bank

This block gathers eight single-cycle event pulses into eight sticky status bits. A bit stays set until the host reads the bank, and the read clears every bit at once. A per-bit mask register decides which status bits may raise the shared interrupt line and the summary bit that feeds a chip-level status word. The mask register resets to all ones, so every source starts masked.

A control register holds one visibility flag. When the flag is clear, an event on a masked source is dropped. When it is set, the event is still recorded in the status bank, so software can poll it. A masked bit still never reaches the interrupt line or the summary bit. The host has three strobes that share one write-data bus: read status, write mask, write control. The current status value is always present on the read-data port.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, rdData is 0, irqOut and sumBit are 0, every mask bit is 1 and the visibility flag is 0.
- R2: A one-cycle pulse on evt[i] for a source that may be captured sets rdData[i] after the next rising edge. The bit then stays set while rdStatus is low.
- R3: rdData always shows the current status. A cycle with rdStatus high clears all status bits at the following edge.
- R4: An event captured in the same cycle as a status read is set after that edge, so it is not lost.
- R5: With the visibility flag at 0, an event on a source whose mask bit is 1 leaves the status bit unchanged.
- R6: With the visibility flag at 1, an event is latched whatever its mask bit.
- R7: irqOut is a register that takes the OR of (status AND NOT mask) at each edge. A latched bit whose mask is 1 never drives it.
- R8: sumBit equals irqOut in every cycle.
- R9: wrMask high loads wrData into the mask register. A mask bit of 1 means masked, and the new mask takes effect from the next cycle.
- R10: wrCtrl high loads wrData bit 0 into the visibility flag. The other bits of wrData are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdStatus | input | 1 | Status read strobe; clears the bank |
| wrMask | input | 1 | Mask register write strobe |
| wrCtrl | input | 1 | Control register write strobe |
| wrData | input | 8 | Host write data |
| evt | input | 8 | Event pulses, one per source |
| rdData | output | 8 | Current status bits |
| irqOut | output | 1 | Interrupt line, active high |
| sumBit | output | 1 | Summary bit for the chip-level status word |

## Verification
The bench drives all-ones bursts against a fully masked bank, with visibility off and then on. Comparing the two runs separates "dropped" from "recorded but silent". Single sparse pulses followed by idle cycles show that bits stick and that the interrupt arrives with one cycle of lag. An event placed in the same cycle as a read separates a clear-then-set order from a set-then-clear order. A long stretch of random strobes, masks and events is then compared every cycle against a behavioural model. This covers overlaps of mask writes, control writes and reads.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic clrStatus;
    logic loadMask;
    logic loadVis;
  } hostStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic        rdStatus,
  input  logic        wrMask,
  input  logic        wrCtrl,
  output hostStrobe_t strobe
);
  always_comb begin
    strobe.clrStatus = rdStatus;
    strobe.loadMask  = wrMask;
    strobe.loadVis   = wrCtrl;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VIS_BIT = 0
)(
  input  logic               clk,
  input  logic               rstN,
  input  hostStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evt,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               visQ,
  output logic               irqQ
);
  logic [NUM_SRC-1:0] captureEn;

  // a source is captured if unmasked, or if visibility is on
  assign captureEn = visQ ? '1 : ~maskQ;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
      end else begin
        // the read clear comes first, a fresh event wins over it
        statusQ[i] <= (statusQ[i] & ~strobe.clrStatus) | (evt[i] & captureEn[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      visQ  <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      if (strobe.loadMask) maskQ <= wrData;
      if (strobe.loadVis)  visQ  <= wrData[VIS_BIT];
      irqQ <= |(statusQ & ~maskQ);
    end
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdStatus,
  input  logic               wrMask,
  input  logic               wrCtrl,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] evt,
  output logic [NUM_SRC-1:0] rdData,
  output logic               irqOut,
  output logic               sumBit
);
  localparam int VIS_BIT = 0;

  hostStrobe_t        strobe;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               visQ;
  logic               irqQ;

  irq_ctrl u_ctrl (
    .rdStatus (rdStatus),
    .wrMask   (wrMask),
    .wrCtrl   (wrCtrl),
    .strobe   (strobe)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .VIS_BIT(VIS_BIT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .evt     (evt),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .visQ    (visQ),
    .irqQ    (irqQ)
  );

  assign rdData = statusQ;
  assign irqOut = irqQ;
  assign sumBit = irqQ;
endmodule

// File: rtl/irq_status_bank_chk.sv
module irq_status_bank_chk #(
  parameter int NUM_SRC = 8
)(
  input logic               clk,
  input logic               rstN,
  input logic               rdStatus,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] rdData,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               visQ,
  input logic               irqOut,
  input logic               sumBit
);
  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sumBit == irqOut); // R8

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> ((rdData & $past(rdData)) == $past(rdData))); // R2

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && evt == '0) |=> (rdData == '0)); // R3

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> ((rdData & $past(evt & ~maskQ)) == $past(evt & ~maskQ))); // R4

  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> ($past(visQ) || ((rdData & ~$past(rdData) & $past(maskQ)) == '0))); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == |($past(rdData) & ~$past(maskQ)))); // R7
endmodule

bind irq_status_bank irq_status_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStatus (rdStatus),
  .evt      (evt),
  .rdData   (rdData),
  .maskQ    (maskQ),
  .visQ     (visQ),
  .irqOut   (irqOut),
  .sumBit   (sumBit)
);

// File: tb/irq_status_bank_tb.sv
`timescale 1ns/1ps
module irq_status_bank_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdStatus = 1'b0, wrMask = 1'b0, wrCtrl = 1'b0;
  logic [7:0] wrData = '0, evt = '0;
  logic [7:0] rdData;
  logic       irqOut, sumBit;

  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  logic [7:0] mStatus = '0, mMask = '1;
  logic       mVis = 1'b0, mIrq = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_bank u_dut (
    .clk(clk), .rstN(rstN), .rdStatus(rdStatus), .wrMask(wrMask),
    .wrCtrl(wrCtrl), .wrData(wrData), .evt(evt), .rdData(rdData),
    .irqOut(irqOut), .sumBit(sumBit)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  // one cycle: drive after a falling edge, advance the model at the rising edge, compare at the next falling edge
  task automatic cyc(input string req, input logic rd, input logic wm, input logic wc,
                     input logic [7:0] d, input logic [7:0] e);
    logic [7:0] cap;
    logic       nIrq;
    rdStatus = rd; wrMask = wm; wrCtrl = wc; wrData = d; evt = e;
    @(posedge clk);
    cap     = e & (mVis ? 8'hFF : ~mMask);
    nIrq    = |(mStatus & ~mMask);
    mStatus = (rd ? 8'h00 : mStatus) | cap;
    if (wm) mMask = d;
    if (wc) mVis = d[0];
    mIrq = nIrq;
    @(negedge clk);
    rdStatus = 0; wrMask = 0; wrCtrl = 0; wrData = '0; evt = '0;
    check(req, "rdData", rdData, mStatus);
    check(req, "irqOut", {7'd0, irqOut}, {7'd0, mIrq});
    check("R8", "sumBit", {7'd0, sumBit}, {7'd0, irqOut});
  endtask

  initial begin
    #(200000 * 5);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rdData", rdData, 8'h00);
    check("R1", "irqOut", {7'd0, irqOut}, 8'h00);
    check("R1", "sumBit", {7'd0, sumBit}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // mask resets to all ones, visibility off: everything dropped
    cyc("R1", 0, 0, 0, 8'h00, 8'hFF);
    check("R5", "masked drop", rdData, 8'h00);
    cyc("R9", 0, 1, 0, 8'h00, 8'h00);
    cyc("R2", 0, 0, 0, 8'h00, 8'h05);
    check("R2", "latched", rdData, 8'h05);
    check("R7", "irq lags status", {7'd0, irqOut}, 8'h00);
    cyc("R7", 0, 0, 0, 8'h00, 8'h00);
    check("R7", "irq raised", {7'd0, irqOut}, 8'h01);
    cyc("R2", 0, 0, 0, 8'h00, 8'h00);
    check("R2", "held", rdData, 8'h05);
    cyc("R4", 1, 0, 0, 8'h00, 8'h20);
    check("R4", "event on read kept", rdData, 8'h20);
    cyc("R3", 1, 0, 0, 8'h00, 8'h00);
    check("R3", "cleared", rdData, 8'h00);
    cyc("R3", 0, 0, 0, 8'h00, 8'h00);
    // visibility on with low nibble masked
    cyc("R9", 0, 1, 0, 8'h0F, 8'h00);
    cyc("R10", 0, 0, 1, 8'hFF, 8'h00);
    cyc("R6", 0, 0, 0, 8'h00, 8'h0F);
    check("R6", "masked recorded", rdData, 8'h0F);
    cyc("R7", 0, 0, 0, 8'h00, 8'h00);
    cyc("R7", 0, 0, 0, 8'h00, 8'h00);
    check("R7", "masked silent", {7'd0, irqOut}, 8'h00);
    cyc("R9", 0, 1, 0, 8'hFE, 8'h00);
    cyc("R9", 0, 0, 0, 8'h00, 8'h00);
    check("R9", "unmask raises irq", {7'd0, irqOut}, 8'h01);
    cyc("R3", 1, 0, 0, 8'h00, 8'h00);
    // bit 0 of wrData only; other bits ignored
    cyc("R10", 0, 0, 1, 8'hFE, 8'h00);
    cyc("R10", 0, 1, 0, 8'hF0, 8'h00);
    cyc("R5", 0, 0, 0, 8'h00, 8'hFF);
    check("R5", "only unmasked", rdData, 8'h0F);
    cyc("R3", 1, 0, 0, 8'h00, 8'h00);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R2", r[0] & r[1], r[2] & r[3] & r[4], r[5] & r[6] & r[7],
          r[15:8], r[23:16] & r[31:24]);
    end
    report();
  end
endmodule